// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the address used by a burst memory on each cycle. A load cycle captures a new external address as the first beat of a burst. Each advance cycle after that moves to the next beat. Only the low address bits take part in the burst. With the default parameter that is two bits, which gives four beats. The upper bits stay as they were loaded.

Two beat orders are offered. Linear order is a wrapping increment. Interleaved order XORs the loaded low bits with the beat number. The order comes from a strap that is meant to be static, and the block samples it while reset is held.

A single advance/load input chooses between loading and stepping. A stall input freezes all state for a clock edge. A select input marks the device as deselected, which drops the valid flag. After a deselect, a load is needed before any advance has effect.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr_vld` is 0 and `cur_addr` is 0.
- R2: An edge with `stall`=0, `sel`=1 and `step`=0 loads the address. From the next cycle `cur_addr` equals the `ext_addr` that was sampled and `addr_vld` is 1. This holds for back-to-back loads too.
- R3: In linear order (strap value 0), the low BW bits of `cur_addr` after k accepted advances are (loaded low bits + k) mod 2^BW. They wrap past the last beat.
- R4: In interleaved order (strap value 1), the low BW bits after k accepted advances are (loaded low bits XOR (k mod 2^BW)).
- R5: An advance never changes `cur_addr` bits AW-1..BW.
- R6: An edge with `stall`=1 changes neither `cur_addr` nor `addr_vld`, whatever `sel`, `step` and `ext_addr` carry.
- R7: An edge with `stall`=0 and `sel`=0 clears `addr_vld`. `cur_addr` then shows the last loaded address with its beat reset to 0.
- R8: An advance (`stall`=0, `sel`=1, `step`=1) while `addr_vld` is 0 is ignored. `addr_vld` stays 0 and `cur_addr` is unchanged.
- R9: `order_sel` is captured while `rst` is high, where 1 selects interleaved and 0 selects linear. Changing it after reset does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 freezes all state for this edge |
| sel | input | 1 | 1 = device selected, 0 = deselected |
| step | input | 1 | 1 = advance the burst, 0 = load `ext_addr` |
| ext_addr | input | AW | Address captured on a load |
| order_sel | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| cur_addr | output | AW | Address of the current beat |
| addr_vld | output | 1 | A loaded burst is active |

## Verification
The hardest state to reach is an advance request that arrives while no burst is valid. It has to be reached twice: straight after reset, and after a deselect that ends a running burst. The stimulus creates both cases and also sends stalled edges that carry a load, a deselect and a step. Each of these must leave the outputs untouched. The strap is changed after a second reset so that its sampling can be observed. Both orders are run for more than four beats to show the wrap.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_DESEL = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } op_e;

    // Priority: stall beats deselect, deselect beats load/step.
    function automatic op_e decode_op(input logic stall, input logic sel, input logic step);
        if (stall)
            return OP_HOLD;
        if (!sel)
            return OP_DESEL;
        if (!step)
            return OP_LOAD;
        return OP_STEP;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (op == OP_LOAD)
            base_q <= ext_addr;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    output logic [BW-1:0] beat_q,
    output logic          vld_q
);

    localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            case (op)
                OP_HOLD: ;
                OP_DESEL: begin
                    beat_q <= '0;
                    vld_q  <= 1'b0;
                end
                OP_LOAD: begin
                    beat_q <= '0;
                    vld_q  <= 1'b1;
                end
                OP_STEP: begin
                    if (vld_q)
                        beat_q <= beat_q + ONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BW = 2
) (
    input  order_e        order,
    input  logic [BW-1:0] base_low,
    input  logic [BW-1:0] beat,
    output logic [BW-1:0] low_out
);

    logic [BW-1:0] lin_low;
    logic [BW-1:0] ilv_low;

    genvar i;
    generate
        for (i = 0; i < BW; i++) begin : g_ilv
            assign ilv_low[i] = base_low[i] ^ beat[i];
        end
    endgenerate

    assign lin_low = base_low + beat;

    always_comb begin
        case (order)
            ORD_LINEAR:     low_out = lin_low;
            ORD_INTERLEAVE: low_out = ilv_low;
            default:        low_out = ilv_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 20,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          sel,
    input  logic          step,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_sel,
    output logic [AW-1:0] cur_addr,
    output logic          addr_vld
);

    op_e           op;
    order_e        order_q;
    logic [AW-1:0] base_q;
    logic [BW-1:0] beat_q;
    logic [BW-1:0] low_bits;

    assign op = decode_op(stall, sel, step);

    // Strap is sampled only during reset.
    always_ff @(posedge clk) begin
        if (rst)
            order_q <= order_sel ? ORD_INTERLEAVE : ORD_LINEAR;
    end

    burst_base_reg #(.AW(AW)) u_base (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ext_addr (ext_addr),
        .base_q   (base_q)
    );

    burst_beat_ctr #(.BW(BW)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .beat_q (beat_q),
        .vld_q  (addr_vld)
    );

    burst_order_map #(.BW(BW)) u_map (
        .order    (order_q),
        .base_low (base_q[BW-1:0]),
        .beat     (beat_q),
        .low_out  (low_bits)
    );

    assign cur_addr = {base_q[AW-1:BW], low_bits};

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
    parameter int AW = 20,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic          sel,
    input logic          step,
    input logic [AW-1:0] ext_addr,
    input logic          order_bit,
    input logic [AW-1:0] cur_addr,
    input logic          addr_vld
);

    localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && sel && !step) |=> (addr_vld && cur_addr == $past(ext_addr)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!stall && sel && step && addr_vld && !order_bit)
        |=> (cur_addr[BW-1:0] == $past(cur_addr[BW-1:0]) + ONE));

    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall && sel && step) |=> (cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])));

    assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(cur_addr) && $stable(addr_vld)));

    assert_desel_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall && !sel) |=> !addr_vld);

    assert_idle_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall && sel && step && !addr_vld) |=> (!addr_vld && $stable(cur_addr)));

    assert_strap_held_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(order_bit));

endmodule

bind burst_addr_gen burst_addr_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .sel       (sel),
    .step      (step),
    .ext_addr  (ext_addr),
    .order_bit (order_q),
    .cur_addr  (cur_addr),
    .addr_vld  (addr_vld)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    localparam int AW = 20;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          sel = 1'b0;
    logic          step = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          addr_vld;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // behavioural reference state
    int m_base = 0;
    int m_k    = 0;
    int m_vld  = 0;
    int m_ilv  = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.AW(AW), .BW(BW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .sel       (sel),
        .step      (step),
        .ext_addr  (ext_addr),
        .order_sel (order_sel),
        .cur_addr  (cur_addr),
        .addr_vld  (addr_vld)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_base = 0; m_k = 0; m_vld = 0; m_ilv = order_sel;
        end else if (!stall) begin
            if (!sel) begin
                m_vld = 0; m_k = 0;
            end else if (!step) begin
                m_base = int'(ext_addr); m_k = 0; m_vld = 1;
            end else if (m_vld != 0) begin
                m_k = (m_k + 1) % 4;
            end
        end
    end

    function automatic int exp_addr();
        int lo;
        lo = m_ilv != 0 ? ((m_base & 3) ^ m_k) : (((m_base & 3) + m_k) % 4);
        return (m_base & ~3) | lo;
    endfunction

    task automatic compare();
        checks++;
        if (int'(cur_addr) != exp_addr() || int'(addr_vld) != m_vld) begin
            fails++;
            $display("FAIL %s: addr=%h vld=%0d expected addr=%h vld=%0d",
                     tag, cur_addr, addr_vld, exp_addr(), m_vld);
        end
    endtask

    task automatic cyc(input logic s_st, input logic s_sel, input logic s_step,
                       input logic [AW-1:0] a);
        stall = s_st; sel = s_sel; step = s_step; ext_addr = a;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; order_sel = strap; stall = 0; sel = 0; step = 0;
        @(negedge clk); @(negedge clk);
        tag = "R1";
        compare();
        rst = 1'b0;
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);                       // linear order
        tag = "R8";                           // advance before any load
        cyc(0, 1, 1, 20'h55555); cyc(0, 1, 1, 20'h0);
        tag = "R2";
        cyc(0, 1, 0, 20'h12345);
        tag = "R3 R5";                        // 1,2,3,0,1,2
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 20'hFFFFF);
        tag = "R6";                           // stalled load, deselect, step
        cyc(1, 1, 0, 20'hABCDE); cyc(1, 0, 1, 20'h0); cyc(1, 1, 1, 20'h0);
        tag = "R3";
        cyc(0, 1, 1, 20'h0);
        tag = "R7";
        cyc(0, 0, 0, 20'h77777);
        tag = "R8";                           // advance after deselect
        cyc(0, 1, 1, 20'h0); cyc(0, 1, 1, 20'h0);
        tag = "R2";                           // back-to-back loads
        cyc(0, 1, 0, 20'hABCDE); cyc(0, 1, 0, 20'h00003);
        tag = "R3";                           // 3 wraps to 0
        cyc(0, 1, 1, 20'h0); cyc(0, 1, 1, 20'h0);

        do_reset(1'b1);                       // interleaved order
        tag = "R9";
        order_sel = 1'b0;                     // strap moves after reset
        cyc(0, 1, 0, 20'h00FF1);
        tag = "R4 R9";                        // 0,3,2,1,0,3
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 20'h0);
        tag = "R6";
        cyc(1, 1, 1, 20'h0); cyc(1, 1, 0, 20'h11112);
        tag = "R2";
        cyc(0, 1, 0, 20'h3C3C3);
        tag = "R4 R5";                        // 3 -> 2,1,0,3
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 20'h0);
        tag = "R7";
        cyc(0, 0, 1, 20'h0);
        tag = "R8";
        cyc(0, 1, 1, 20'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule